// File: doc/BRIEF.md
# Adaptive Redundancy Mode Controller

This block chooses how many lockstep soft processors a reconfigurable fabric runs, with three choices: one, two or three copies. It counts fault events reported by a configuration scrubber over a fixed observation window. At the end of each window it compares the count with two programmable thresholds. It raises the redundancy level at once. It lowers the level only after two windows in a row fall below the current level. A ground command can override this choice: it pins a mode for a given number of clock cycles, and when that time runs out the adaptive choice takes over again.

When the decided mode differs from the running mode, the block requests a reload of only those fabric regions whose role changes. Region `i` holds a processor copy when `i` is below the processor count of the mode; otherwise it holds an accelerator. The new mode takes effect only once every requested region reports that its reload is done. If the number of processors grew, a one-cycle reset pulse then resynchronises the processor array.

The sequencer has three states. `ST_STABLE` is the resting state and moves to `ST_LOADING` when the decided mode differs from the running one. `ST_LOADING` waits for the done signals. When the last one arrives it moves to `ST_RESYNC` if the processor count grew, or back to `ST_STABLE` if it shrank. `ST_RESYNC` lasts one cycle and returns to `ST_STABLE`.

Top module: `adaptive_mode_ctl`

## Requirements
- R1: Reset leaves the running mode at simplex (code 0), with no region request and no array reset.
- R2: Mode codes are simplex=0, duplex=1, triplex=2, and code 3 never appears. A window lasts WIN cycles and counts every cycle with `fault_evt` high, saturating at the counter width. At the window's last cycle the count maps to a level: below `thr_lo` gives simplex, from `thr_lo` up to but not including `thr_hi` gives duplex, and `thr_hi` or more gives triplex. The count then restarts from zero.
- R3: When `thr_lo` exceeds `thr_hi`, `thr_hi` serves as both bounds, so counts below it give simplex and counts at or above it give triplex.
- R4: A window level above the decided mode is adopted at that window's end.
- R5: A window level below the decided mode only arms a pending drop. A second consecutive window below the decided mode adopts that second window's level. A window at or above the decided mode clears the pending drop.
- R6: On a change from mode a to mode b, `region_load[i]` is raised for exactly the regions with min(a,b)+1 <= i < max(a,b)+1. Each bit stays high until its `region_done` bit is seen, and no request is high during an array reset.
- R7: `mode_o` keeps its old value while any request is pending, and takes the new value in the cycle after the last pending `region_done`.
- R8: `array_reset` is a single-cycle pulse, given in the cycle after the new mode is taken, and only when the new mode has more processors than the old one.
- R9: `force_valid` with a nonzero `force_ticks` sets the decided mode to `force_mode` (code 3 treated as triplex) for `force_ticks` cycles. During that time window levels do not change the decision, and a later force command replaces the running one.
- R10: When a force period ends, the decided mode becomes the level of the most recently completed window.
- R11: A force command with `force_ticks` equal to zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_evt | input | 1 | One fault event in this cycle |
| thr_lo | input | CW | Lower fault-count threshold |
| thr_hi | input | CW | Upper fault-count threshold |
| force_valid | input | 1 | Ground override command strobe |
| force_mode | input | 2 | Mode requested by the override |
| force_ticks | input | DW | Override duration in cycles |
| region_done | input | NREG | Per-region reload complete pulse |
| mode_o | output | 2 | Running redundancy mode |
| region_load | output | NREG | Per-region reload request |
| array_reset | output | 1 | Processor array resynchronisation pulse |

## Verification
On every cycle the assertions check the handshake and commit rules. A request bit may drop only after its done pulse. The mode may move only in the cycle the last request clears. The reset pulse is one cycle long, follows only a growth in processor count, and never overlaps a request. The bench scenarios show the rest: the threshold mapping and its boundaries, the swapped-threshold rule, the two-window hysteresis and how it is cancelled, the exact region masks for each pair of modes, and the timing of force periods, their expiry and the ignored zero-length command.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;

    typedef enum logic [1:0] {
        MODE_SIMPLEX = 2'd0,
        MODE_DUPLEX  = 2'd1,
        MODE_TRIPLEX = 2'd2
    } rmode_e;

    typedef enum logic [1:0] {
        ST_STABLE  = 2'd0,
        ST_LOADING = 2'd1,
        ST_RESYNC  = 2'd2
    } seq_state_e;

    // number of lockstep processor copies a mode occupies
    function automatic logic [2:0] cpu_count(input rmode_e m);
        return 3'(m) + 3'd1;
    endfunction

endpackage

// File: rtl/fault_window.sv
module fault_window
    import mode_ctl_pkg::*;
#(
    parameter int WIN = 64,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_evt,
    input  logic [CW-1:0] thr_lo,
    input  logic [CW-1:0] thr_hi,
    output logic          win_end,
    output rmode_e        win_level,
    output rmode_e        last_level
);
    localparam int TW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [TW-1:0] LAST_TICK = TW'(WIN - 1);

    logic [TW-1:0] tick_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] total;
    logic [CW-1:0] lo_eff;
    rmode_e        level_q;

    assign win_end = (tick_q == LAST_TICK);

    always_comb begin
        total = cnt_q;
        if (fault_evt && !(&cnt_q)) begin
            total = cnt_q + 1'b1;
        end
    end

    // swapped thresholds collapse the duplex band
    assign lo_eff = (thr_lo > thr_hi) ? thr_hi : thr_lo;

    always_comb begin
        if (total < lo_eff) begin
            win_level = MODE_SIMPLEX;
        end else if (total < thr_hi) begin
            win_level = MODE_DUPLEX;
        end else begin
            win_level = MODE_TRIPLEX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= '0;
            cnt_q   <= '0;
            level_q <= MODE_SIMPLEX;
        end else begin
            if (win_end) begin
                tick_q  <= '0;
                cnt_q   <= '0;
                level_q <= win_level;
            end else begin
                tick_q  <= tick_q + 1'b1;
                cnt_q   <= total;
            end
        end
    end

    assign last_level = level_q;

endmodule

// File: rtl/mode_decider.sv
module mode_decider
    import mode_ctl_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_end,
    input  rmode_e        win_level,
    input  rmode_e        last_level,
    input  logic          force_valid,
    input  logic [1:0]    force_mode,
    input  logic [DW-1:0] force_ticks,
    output rmode_e        want
);
    localparam logic [DW-1:0] ONE_TICK = DW'(1);

    rmode_e        want_q, want_d;
    logic          pend_q, pend_d;
    logic          forced_q, forced_d;
    logic [DW-1:0] left_q, left_d;
    rmode_e        req_mode;

    assign req_mode = (force_mode == 2'd3) ? MODE_TRIPLEX : rmode_e'(force_mode);

    always_comb begin
        want_d   = want_q;
        pend_d   = pend_q;
        forced_d = forced_q;
        left_d   = left_q;
        if (force_valid && (force_ticks != '0)) begin
            forced_d = 1'b1;
            left_d   = force_ticks;
            want_d   = req_mode;
            pend_d   = 1'b0;
        end else if (forced_q) begin
            if (left_q == ONE_TICK) begin
                forced_d = 1'b0;
                left_d   = '0;
                want_d   = win_end ? win_level : last_level;
                pend_d   = 1'b0;
            end else begin
                left_d = left_q - 1'b1;
            end
        end else if (win_end) begin
            if (win_level > want_q) begin
                want_d = win_level;
                pend_d = 1'b0;
            end else if (win_level < want_q) begin
                if (pend_q) begin
                    want_d = win_level;
                    pend_d = 1'b0;
                end else begin
                    pend_d = 1'b1;
                end
            end else begin
                pend_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_q   <= MODE_SIMPLEX;
            pend_q   <= 1'b0;
            forced_q <= 1'b0;
            left_q   <= '0;
        end else begin
            want_q   <= want_d;
            pend_q   <= pend_d;
            forced_q <= forced_d;
            left_q   <= left_d;
        end
    end

    assign want = want_q;

endmodule

// File: rtl/region_planner.sv
module region_planner
    import mode_ctl_pkg::*;
#(
    parameter int NREG = 4
) (
    input  rmode_e            from_mode,
    input  rmode_e            to_mode,
    output logic [NREG-1:0]   mask,
    output logic              grows
);
    logic [2:0] n_from, n_to, lo, hi;

    always_comb begin
        n_from = cpu_count(from_mode);
        n_to   = cpu_count(to_mode);
        lo     = (n_from < n_to) ? n_from : n_to;
        hi     = (n_from < n_to) ? n_to : n_from;
        grows  = (n_to > n_from);
    end

    // region i carries a processor copy while i < processor count
    for (genvar i = 0; i < NREG; i++) begin : g_region
        assign mask[i] = (i >= int'(lo)) && (i < int'(hi));
    end

endmodule

// File: rtl/adaptive_mode_ctl.sv
module adaptive_mode_ctl
    import mode_ctl_pkg::*;
#(
    parameter int NREG = 4,
    parameter int CW   = 8,
    parameter int WIN  = 64,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault_evt,
    input  logic [CW-1:0]   thr_lo,
    input  logic [CW-1:0]   thr_hi,
    input  logic            force_valid,
    input  logic [1:0]      force_mode,
    input  logic [DW-1:0]   force_ticks,
    input  logic [NREG-1:0] region_done,
    output logic [1:0]      mode_o,
    output logic [NREG-1:0] region_load,
    output logic            array_reset
);
    logic            win_end;
    rmode_e          win_level, last_level, want;
    logic [NREG-1:0] plan_mask;
    logic            plan_grows;

    seq_state_e      state_q, state_d;
    rmode_e          cur_q, cur_d, nxt_q, nxt_d;
    logic [NREG-1:0] pend_q, pend_d;
    logic            grow_q, grow_d;
    logic [NREG-1:0] remain;

    fault_window #(.WIN(WIN), .CW(CW)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_evt  (fault_evt),
        .thr_lo     (thr_lo),
        .thr_hi     (thr_hi),
        .win_end    (win_end),
        .win_level  (win_level),
        .last_level (last_level)
    );

    mode_decider #(.DW(DW)) u_decider (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_end     (win_end),
        .win_level   (win_level),
        .last_level  (last_level),
        .force_valid (force_valid),
        .force_mode  (force_mode),
        .force_ticks (force_ticks),
        .want        (want)
    );

    region_planner #(.NREG(NREG)) u_planner (
        .from_mode (cur_q),
        .to_mode   (want),
        .mask      (plan_mask),
        .grows     (plan_grows)
    );

    assign remain = pend_q & ~region_done;

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        nxt_d   = nxt_q;
        pend_d  = pend_q;
        grow_d  = grow_q;
        unique case (state_q)
            ST_STABLE: begin
                if (want != cur_q) begin
                    state_d = ST_LOADING;
                    nxt_d   = want;
                    pend_d  = plan_mask;
                    grow_d  = plan_grows;
                end
            end
            ST_LOADING: begin
                pend_d = remain;
                if (remain == '0) begin
                    cur_d   = nxt_q;
                    state_d = grow_q ? ST_RESYNC : ST_STABLE;
                end
            end
            ST_RESYNC: begin
                state_d = ST_STABLE;
            end
            default: begin
                state_d = ST_STABLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
            cur_q   <= MODE_SIMPLEX;
            nxt_q   <= MODE_SIMPLEX;
            pend_q  <= '0;
            grow_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            nxt_q   <= nxt_d;
            pend_q  <= pend_d;
            grow_q  <= grow_d;
        end
    end

    always_comb begin
        mode_o      = 2'(cur_q);
        region_load = (state_q == ST_LOADING) ? pend_q : '0;
        array_reset = (state_q == ST_RESYNC);
    end

endmodule

// File: rtl/mode_ctl_checker.sv
module mode_ctl_checker #(
    parameter int NREG = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mode_o,
    input logic [NREG-1:0] region_load,
    input logic [NREG-1:0] region_done,
    input logic            array_reset
);
    // R2
    mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);

    // R6
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region_load != '0) |=>
        (($past(region_load) & ~$past(region_done) & ~region_load) == '0));

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(array_reset && (region_load != '0)));

    // R7
    commit_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> (($past(region_load) != '0) && (region_load == '0)));

    // R8
    reset_on_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        array_reset |-> (mode_o > $past(mode_o)));

    // R8
    reset_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        array_reset |=> !array_reset);

endmodule

bind adaptive_mode_ctl mode_ctl_checker #(.NREG(NREG)) u_mode_ctl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_o      (mode_o),
    .region_load (region_load),
    .region_done (region_done),
    .array_reset (array_reset)
);

// File: tb/tb_adaptive_mode_ctl.sv
module tb_adaptive_mode_ctl;
    localparam int CLK_NS = 10;
    localparam int NREG   = 4;
    localparam int CW     = 8;
    localparam int WIN    = 64;
    localparam int DW     = 16;
    localparam int CHK_AT = 20;
    localparam int INJ_AT = 24;
    localparam int NV     = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            fault_evt;
    logic [CW-1:0]   thr_lo, thr_hi;
    logic            force_valid;
    logic [1:0]      force_mode;
    logic [DW-1:0]   force_ticks;
    logic [NREG-1:0] region_done;
    logic [1:0]      mode_o;
    logic [NREG-1:0] region_load;
    logic            array_reset;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int rst_cnt = 0;
    logic [NREG-1:0] seen_mask = '0;
    bit   in_load = 1'b0;
    logic [1:0] mode_hold = '0;

    adaptive_mode_ctl #(.NREG(NREG), .CW(CW), .WIN(WIN), .DW(DW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_evt   (fault_evt),
        .thr_lo      (thr_lo),
        .thr_hi      (thr_hi),
        .force_valid (force_valid),
        .force_mode  (force_mode),
        .force_ticks (force_ticks),
        .region_done (region_done),
        .mode_o      (mode_o),
        .region_load (region_load),
        .array_reset (array_reset)
    );

    always #(CLK_NS / 2) clk = ~clk;

    // row: {faults[3:0], mode[1:0], mask[3:0], reset}, thresholds 3 / 6
    localparam logic [10:0] VEC [NV] = '{
        {4'd0, 2'd0, 4'b0000, 1'b0},  // R2 below T1 stays simplex
        {4'd4, 2'd1, 4'b0010, 1'b1},  // R4 up to duplex
        {4'd7, 2'd2, 4'b0100, 1'b1},  // R4 up to triplex
        {4'd0, 2'd2, 4'b0000, 1'b0},  // R5 first low window arms
        {4'd4, 2'd1, 4'b0100, 1'b0},  // R5 second low window drops
        {4'd8, 2'd2, 4'b0100, 1'b1},  // R4
        {4'd2, 2'd2, 4'b0000, 1'b0},  // R5 arm
        {4'd7, 2'd2, 4'b0000, 1'b0},  // R5 cancel
        {4'd1, 2'd2, 4'b0000, 1'b0},  // R5 arm again
        {4'd0, 2'd0, 4'b0110, 1'b0},  // R5 triplex to simplex
        {4'd6, 2'd2, 4'b0110, 1'b1},  // R2 count equal T2
        {4'd5, 2'd2, 4'b0000, 1'b0},  // R5 arm with duplex level
        {4'd2, 2'd0, 4'b0110, 1'b0},  // R5 drop to latest level
        {4'd3, 2'd1, 4'b0010, 1'b1},  // R2 count equal T1
        {4'd2, 2'd1, 4'b0000, 1'b0},  // R5 arm
        {4'd2, 2'd0, 4'b0010, 1'b0}   // R5 duplex to simplex
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_row(input string req, input logic [1:0] e_mode,
                             input logic [NREG-1:0] e_mask, input bit e_rst);
        chk(mode_o == e_mode, {req, " mode"}, int'(mode_o), int'(e_mode));
        chk(seen_mask == e_mask, "R6 region mask", int'(seen_mask), int'(e_mask));
        chk(rst_cnt == int'(e_rst), "R8 reset pulses", rst_cnt, int'(e_rst));
        seen_mask = '0;
        rst_cnt   = 0;
    endtask

    // one window; entered at a negedge just before the window's first edge
    task automatic do_window(input int nf, input bit do_chk, input string req,
                             input logic [1:0] e_mode, input logic [NREG-1:0] e_mask,
                             input bit e_rst, input int force_at,
                             input logic [1:0] fmode, input int fticks);
        for (int c = 0; c < WIN; c++) begin
            fault_evt   = (c >= INJ_AT) && (c < INJ_AT + nf);
            force_valid = (c == force_at);
            force_mode  = fmode;
            force_ticks = DW'(fticks);
            if (do_chk && c == CHK_AT) check_row(req, e_mode, e_mask, e_rst);
            @(negedge clk);
        end
        fault_evt   = 1'b0;
        force_valid = 1'b0;
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // monitor: accumulates requests and pulses, checks commit timing
    always @(negedge clk) begin
        if (rst_n) begin
            seen_mask = seen_mask | region_load;
            if (array_reset) rst_cnt = rst_cnt + 1;
            if (region_load != '0) begin
                if (!in_load) begin
                    in_load   = 1'b1;
                    mode_hold = mode_o;
                end else begin
                    chk(mode_o == mode_hold, "R7 mode held during load", int'(mode_o), int'(mode_hold));
                end
            end else if (in_load) begin
                in_load = 1'b0;
                chk(mode_o != mode_hold, "R7 mode taken after last done", int'(mode_o), int'(mode_hold));
            end
        end
    end

    // responder: one region done every third cycle, lowest first
    initial begin
        int dly;
        dly = 0;
        region_done = '0;
        forever begin
            @(negedge clk);
            region_done = '0;
            if (rst_n && region_load != '0) begin
                dly++;
                if (dly == 3) begin
                    region_done = region_load & (~region_load + 1'b1);
                    dly = 0;
                end
            end else begin
                dly = 0;
            end
        end
    end

    initial begin
        #(CLK_NS * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        fault_evt   = 1'b0;
        thr_lo      = 8'd3;
        thr_hi      = 8'd6;
        force_valid = 1'b0;
        force_mode  = 2'd0;
        force_ticks = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(mode_o == 2'd0, "R1 mode", int'(mode_o), 0);
        chk(region_load == '0, "R1 requests", int'(region_load), 0);
        chk(array_reset == 1'b0, "R1 array reset", int'(array_reset), 0);
        rst_n = 1'b1;

        for (int k = 0; k <= NV; k++) begin
            if (k == 0) begin
                do_window(int'(VEC[0][10:7]), 1'b0, "", 2'd0, '0, 1'b0, -1, 2'd0, 0);
            end else begin
                do_window((k < NV) ? int'(VEC[k][10:7]) : 0, 1'b1, "R2",
                          VEC[k-1][6:5], VEC[k-1][4:1], VEC[k-1][0], -1, 2'd0, 0);
            end
        end

        // R3 swapped thresholds: 2 faults reach triplex
        thr_lo = 8'd5;
        thr_hi = 8'd2;
        do_window(2, 1'b0, "", 2'd0, '0, 1'b0, -1, 2'd0, 0);
        do_window(1, 1'b1, "R3", 2'd2, 4'b0110, 1'b1, -1, 2'd0, 0);
        do_window(2, 1'b1, "R5 single low window", 2'd2, 4'b0000, 1'b0, -1, 2'd0, 0);
        thr_lo = 8'd3;
        thr_hi = 8'd6;
        // R9 force duplex for 150 cycles
        do_window(0, 1'b1, "R3", 2'd2, 4'b0000, 1'b0, 30, 2'd1, 150);
        do_window(8, 1'b1, "R9 forced", 2'd1, 4'b0100, 1'b0, -1, 2'd0, 0);
        do_window(0, 1'b1, "R9 faults ignored", 2'd1, 4'b0000, 1'b0, -1, 2'd0, 0);
        // R10 expiry returns to last window level (triplex)
        do_window(8, 1'b1, "R10 expiry", 2'd2, 4'b0100, 1'b1, -1, 2'd0, 0);
        // R11 zero-length force ignored
        do_window(0, 1'b1, "R10", 2'd2, 4'b0000, 1'b0, 30, 2'd0, 0);
        do_window(8, 1'b1, "R11 zero ticks", 2'd2, 4'b0000, 1'b0, 40, 2'd0, 100);
        do_window(8, 1'b1, "R9 forced simplex", 2'd0, 4'b0110, 1'b0, -1, 2'd0, 0);
        do_window(0, 1'b0, "", 2'd0, '0, 1'b0, -1, 2'd0, 0);
        do_window(8, 1'b1, "R10 expiry to triplex", 2'd2, 4'b0110, 1'b1, -1, 2'd0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule